// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block carries inter-processor interrupts between the cores of a small multi-core cluster. Any core writes a send word that names a software interrupt number and a filter; the block works out which cores receive it and records the interrupt as pending for each of them, tagged with the sending core. The state is kept separately for every receiving core, every interrupt number and every sender.

Each core reads its own acknowledge register to take the most urgent pending interrupt. The read returns the interrupt number and the sender, and it moves that interrupt from pending to active. Once its handler is done, the core retires the interrupt with an end-of-interrupt write, or it clears the active state directly through a write-1-to-clear register.

All cores share one register port. The `req_core` input names the core that issues each access. Every core has its own request line, which is high while that core has something it can acknowledge.

Top module: `sgi_dispatch`

## Requirements
- R1: After reset nothing is pending or active, every `irq_o` bit is low, and an acknowledge read returns 1023.
- R2: A write to offset 0x0 sends the interrupt whose number is in bits [3:0]. The filter in bits [25:24] set to 0 targets every core whose bit is set in the list in bits [23:16] (bit n is core n).
- R3: Filter value 1 targets every core except the writing core.
- R4: Filter value 2 targets only the writing core.
- R5: Filter value 3 targets no core and leaves all state unchanged.
- R6: A read of offset 0x4 is an acknowledge by `req_core`. One cycle later `rsp_rdata` holds the number in bits [9:0] and the sender in bits [12:10], with all other bits zero.
- R7: An acknowledge takes the lowest-numbered eligible interrupt and, within that number, the lowest-numbered sender.
- R8: With nothing eligible, an acknowledge returns exactly 1023 (0x3FF) and changes no state.
- R9: An acknowledged number stays active for that core. While it is active it is not eligible and cannot be acknowledged again. A write to offset 0x8 with the number in bits [9:0] ends its active state.
- R10: A write to offset 0xC clears the writing core's active state for every interrupt number whose bit is set in bits [15:0].
- R11: A repeated send of the same number from the same sender to a core that still has it pending merges into one pending entry.
- R12: `irq_o[n]` is high exactly when core n has at least one pending interrupt whose number is not active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_core | input | 3 | Core issuing the access |
| req_addr | input | 4 | Byte offset; bits [3:2] select the register |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, one cycle after the read |
| irq_o | output | 8 | Per-core interrupt request |

## Verification
On every cycle the assertions check three things:
- the shape of each acknowledge word, with no stray bits and a number that is either in range or the spurious value with a zero sender field;
- that the request line agrees with what an acknowledge returns;
- that a send with filter 3 leaves every request line unchanged.

Only the bench scenarios can show the rest. These are the target sets of the three live filters, the lowest-number-then-lowest-sender ordering, merging of repeated sends, and the way the active state blocks a number until either retirement path clears it.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
  localparam int unsigned SPURIOUS_ID = 1023;

  typedef enum logic [1:0] {
    FLT_LIST   = 2'd0,
    FLT_OTHERS = 2'd1,
    FLT_SELF   = 2'd2,
    FLT_NONE   = 2'd3
  } flt_e;

  typedef enum logic [1:0] {
    REG_SEND = 2'd0,
    REG_ACK  = 2'd1,
    REG_EOI  = 2'd2,
    REG_ACLR = 2'd3
  } reg_e;
endpackage

// File: rtl/sgi_target_decode.sv
module sgi_target_decode #(
  parameter int NCORE = 8,
  localparam int CW = (NCORE > 1) ? $clog2(NCORE) : 1
) (
  input  logic [1:0]       flt,
  input  logic [7:0]       list,
  input  logic [CW-1:0]    src,
  output logic [NCORE-1:0] tgt
);
  import sgi_pkg::*;

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    always_comb begin
      unique case (flt_e'(flt))
        FLT_LIST:   tgt[c] = list[c];
        FLT_OTHERS: tgt[c] = (src != CW'(c));
        FLT_SELF:   tgt[c] = (src == CW'(c));
        default:    tgt[c] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/sgi_core_slot.sv
module sgi_core_slot #(
  parameter int NCORE = 8,
  parameter int NSGI  = 16,
  localparam int CW = (NCORE > 1) ? $clog2(NCORE) : 1,
  localparam int IW = (NSGI > 1) ? $clog2(NSGI) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            snd_en,
  input  logic [IW-1:0]   snd_id,
  input  logic [CW-1:0]   snd_src,
  input  logic            ack_en,
  input  logic            eoi_en,
  input  logic [9:0]      eoi_id,
  input  logic            aclr_en,
  input  logic [NSGI-1:0] aclr_mask,
  output logic            irq,
  output logic [31:0]     ack_word
);
  import sgi_pkg::*;

  logic [NSGI-1:0][NCORE-1:0] pend_q, pend_d;
  logic [NSGI-1:0]            act_q, act_d;
  logic                       found, src_found, upd;
  logic [IW-1:0]              sel_id;
  logic [CW-1:0]              sel_src;

  // lowest eligible number, then lowest sender within it
  always_comb begin
    found  = 1'b0;
    sel_id = '0;
    for (int i = 0; i < NSGI; i++) begin
      if (!found && (|pend_q[i]) && !act_q[i]) begin
        found  = 1'b1;
        sel_id = IW'(i);
      end
    end
    src_found = 1'b0;
    sel_src   = '0;
    for (int s = 0; s < NCORE; s++) begin
      if (!src_found && pend_q[sel_id][s]) begin
        src_found = 1'b1;
        sel_src   = CW'(s);
      end
    end
  end

  assign irq      = found;
  assign ack_word = found ? {19'b0, 3'(sel_src), 10'(sel_id)} : 32'(SPURIOUS_ID);

  always_comb begin
    pend_d = pend_q;
    act_d  = act_q;
    if (snd_en) pend_d[snd_id][snd_src] = 1'b1;
    if (ack_en && found) begin
      pend_d[sel_id][sel_src] = 1'b0;
      act_d[sel_id]           = 1'b1;
    end
    if (eoi_en && (eoi_id < 10'(NSGI))) act_d[eoi_id[IW-1:0]] = 1'b0;
    if (aclr_en) act_d = act_d & ~aclr_mask;
  end

  assign upd = snd_en | ack_en | eoi_en | aclr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
    end else if (upd) begin
      pend_q <= pend_d;
      act_q  <= act_d;
    end
  end
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch #(
  parameter int NCORE = 8,
  parameter int NSGI  = 16,
  parameter int AW    = 4,
  localparam int CW = (NCORE > 1) ? $clog2(NCORE) : 1,
  localparam int IW = (NSGI > 1) ? $clog2(NSGI) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [CW-1:0]    req_core,
  input  logic [AW-1:0]    req_addr,
  input  logic [31:0]      req_wdata,
  output logic [31:0]      rsp_rdata,
  output logic [NCORE-1:0] irq_o
);
  import sgi_pkg::*;

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  reg_e             reg_sel;
  logic             wr, rd;
  logic [NCORE-1:0] tgt;
  logic [31:0]      ack_word [NCORE];
  logic [31:0]      rdata_d, rdata_q;

  assign reg_sel = reg_e'(req_addr[3:2]);
  assign wr      = req_valid & req_write;
  assign rd      = req_valid & ~req_write;

  sgi_target_decode #(.NCORE(NCORE)) u_tgt (
    .flt  (req_wdata[25:24]),
    .list (req_wdata[23:16]),
    .src  (req_core),
    .tgt  (tgt)
  );

  for (genvar c = 0; c < NCORE; c++) begin : g_slot
    logic is_me;
    assign is_me = (req_core == CW'(c));
    sgi_core_slot #(.NCORE(NCORE), .NSGI(NSGI)) u_slot (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .snd_en    (wr && reg_sel == REG_SEND && tgt[c]),
      .snd_id    (req_wdata[IW-1:0]),
      .snd_src   (req_core),
      .ack_en    (rd && reg_sel == REG_ACK && is_me),
      .eoi_en    (wr && reg_sel == REG_EOI && is_me),
      .eoi_id    (req_wdata[9:0]),
      .aclr_en   (wr && reg_sel == REG_ACLR && is_me),
      .aclr_mask (req_wdata[NSGI-1:0]),
      .irq       (irq_o[c]),
      .ack_word  (ack_word[c])
    );
  end

  assign rdata_d = (reg_sel == REG_ACK) ? ack_word[req_core] : 32'b0;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) rdata_q <= '0;
    else if (rd)    rdata_q <= rdata_d;
  end

  assign rsp_rdata = rdata_q;
endmodule

// File: rtl/sgi_dispatch_chk.sv
module sgi_dispatch_chk #(
  parameter int NCORE = 8,
  parameter int NSGI  = 16,
  parameter int AW    = 4,
  localparam int CW = (NCORE > 1) ? $clog2(NCORE) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_write,
  input logic [CW-1:0]    req_core,
  input logic [AW-1:0]    req_addr,
  input logic [31:0]      req_wdata,
  input logic [31:0]      rsp_rdata,
  input logic [NCORE-1:0] irq_o
);
  logic ack_rd, snd_none;
  assign ack_rd   = req_valid && !req_write && req_addr[3:2] == 2'd1;
  assign snd_none = req_valid && req_write && req_addr[3:2] == 2'd0
                    && req_wdata[25:24] == 2'd3;

  p_ack_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_rdata[31:13] == '0);

  p_ack_id_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_rdata[9:0] < 10'(NSGI)) || (rsp_rdata[9:0] == 10'd1023));

  p_spurious_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_rdata[9:0] == 10'd1023 |-> rsp_rdata[12:10] == 3'd0);

  p_idle_ack_spurious_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ack_rd && !irq_o[req_core] |=> rsp_rdata[9:0] == 10'd1023);

  p_busy_ack_real_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ack_rd && irq_o[req_core] |=> rsp_rdata[9:0] != 10'd1023);

  p_filter_none_r5: assert property (@(posedge clk) disable iff (!rst_n)
    snd_none |=> $stable(irq_o));
endmodule

bind sgi_dispatch sgi_dispatch_chk #(.NCORE(NCORE), .NSGI(NSGI), .AW(AW)) u_chk (.*);

// File: tb/sgi_dispatch_test.sv
`timescale 1ns/1ps
module sgi_dispatch_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [2:0]  req_core;
  logic [3:0]  req_addr;
  logic [31:0] req_wdata;
  logic [31:0] rsp_rdata;
  logic [7:0]  irq_o;

  int total = 0;
  int bad   = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #2.5 clk = ~clk;

  sgi_dispatch uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_core(req_core), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .irq_o(irq_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus(logic w, logic [2:0] core, logic [3:0] addr, logic [31:0] data);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_core = core; req_addr = addr; req_wdata = data;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic send(logic [2:0] core, logic [1:0] flt, logic [7:0] list, logic [3:0] id);
    bus(1'b1, core, 4'h0, {6'b0, flt, list, 12'b0, id});
  endtask

  task automatic ack(logic [2:0] core, logic [31:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus(1'b0, core, 4'h4, 32'b0);
  endtask

  task automatic do_reset();
    req_valid = 1'b0; req_write = 1'b0; req_core = '0; req_addr = '0; req_wdata = '0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // monitor: compare every acknowledge response against the scoreboard
  initial begin
    forever begin
      logic fire;
      @(posedge clk);
      fire = req_valid && !req_write && req_addr == 4'h4;
      #1;
      if (fire) begin
        if (exp_q.size() == 0) begin
          total++; bad++;
          $display("FAIL R6 actual=0x%0h expected=<none>", rsp_rdata);
        end else begin
          chk(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 irq after reset", 32'(irq_o), 32'h0);
    ack(3'd0, 32'd1023, "R1 ack after reset");

    // R4 self only
    send(3'd1, 2'd2, 8'h00, 4'd1);
    chk("R4 self irq", 32'(irq_o), 32'h02);
    ack(3'd1, 32'h401, "R6 self ack word");
    chk("R12 irq drops", 32'(irq_o), 32'h0);
    ack(3'd1, 32'd1023, "R8 nothing eligible");

    // R3 all except sender
    do_reset();
    send(3'd1, 2'd1, 8'h00, 4'd5);
    chk("R3 others irq", 32'(irq_o), 32'hFD);
    ack(3'd3, 32'h405, "R3 receiver ack");
    ack(3'd1, 32'd1023, "R3 sender excluded");

    // R2 explicit list
    do_reset();
    send(3'd0, 2'd0, 8'hA5, 4'd7);
    chk("R2 list irq", 32'(irq_o), 32'hA5);
    ack(3'd7, 32'h007, "R2 list ack");

    // R5 filter 3
    do_reset();
    send(3'd0, 2'd3, 8'hFF, 4'd1);
    chk("R5 no target", 32'(irq_o), 32'h0);

    // R7 ordering
    do_reset();
    send(3'd2, 2'd2, 8'h00, 4'd9);
    send(3'd4, 2'd0, 8'h04, 4'd3);
    chk("R7 irq core2", 32'(irq_o), 32'h04);
    ack(3'd2, 32'h1003, "R7 lowest id first");
    ack(3'd2, 32'h809, "R7 next id");
    ack(3'd2, 32'd1023, "R8 drained");

    // R11 merge, R9 active blocking and EOI
    do_reset();
    send(3'd3, 2'd0, 8'h01, 4'd6);
    send(3'd3, 2'd0, 8'h01, 4'd6);
    send(3'd5, 2'd0, 8'h01, 4'd6);
    ack(3'd0, 32'hC06, "R7 lowest sender");
    chk("R9 irq blocked while active", 32'(irq_o), 32'h0);
    ack(3'd0, 32'd1023, "R9 active blocks ack");
    bus(1'b1, 3'd0, 4'h8, 32'hC06);
    chk("R9 irq after eoi", 32'(irq_o), 32'h01);
    ack(3'd0, 32'h1406, "R9 second sender after eoi");
    bus(1'b1, 3'd0, 4'h8, 32'h1406);
    ack(3'd0, 32'd1023, "R11 duplicate merged");

    // R10 active clear
    do_reset();
    send(3'd6, 2'd2, 8'h00, 4'd2);
    ack(3'd6, 32'h1802, "R10 first ack");
    send(3'd6, 2'd2, 8'h00, 4'd2);
    chk("R10 blocked before clear", 32'(irq_o), 32'h0);
    bus(1'b1, 3'd6, 4'hC, 32'h0004);
    chk("R10 irq after clear", 32'(irq_o), 32'h40);
    ack(3'd6, 32'h1802, "R10 ack after clear");

    repeat (2) @(negedge clk);
    chk("R6 scoreboard drained", 32'(exp_q.size()), 32'h0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule